// File: doc/BRIEF.md
# Serial Terminal Port

This block sits between a character terminal that talks one bit at a time and the accumulator of a small processor that moves whole characters in parallel. Each direction has its own 8-bit register and a one-bit handshake flag. On the receive side, bits from the terminal are collected, most significant bit first, one per receive strobe. Once a full character has been collected, the receive flag is raised and the register is frozen until the processor reads it.

On the transmit side, the processor may load a character only while the transmit flag shows the device as ready. Loading clears the flag. The terminal then takes the character one bit per transmit strobe, most significant bit first. The flag returns to ready once the last bit has been taken. The processor polls both flags and uses them to decide when to read and when to load.

Top module: `serial_term_port`

## Requirements
- R1: After reset, `rx_full` is 0, `tx_ready` is 1, `term_tx_bit` is 0 and `cpu_rdata` is 0.
- R2: Each cycle with `term_rx_strobe` high and `rx_full` low shifts `term_rx_bit` into bit 0 of the receive register and moves the other bits up by one. The first bit received therefore ends in bit 7. `rx_full` rises on the clock edge that takes the eighth bit and stays low after fewer bits.
- R3: While `rx_full` is 1, receive strobes are ignored. `cpu_rdata` keeps its value, and the bit counter does not advance, so the next character after a read starts fresh.
- R4: `cpu_rdata` always shows the receive register in parallel. A `cpu_rd` pulse while `rx_full` is 1 clears `rx_full` on the same clock edge.
- R5: A `cpu_ld` pulse while `tx_ready` is 1 copies `cpu_wdata` into the transmit register and clears `tx_ready` on that edge. `term_tx_bit` then shows bit 7 of the loaded character.
- R6: A `cpu_ld` pulse while `tx_ready` is 0 is ignored, and the character in flight is sent unchanged.
- R7: Each `term_tx_strobe` while `tx_ready` is 0 shifts the transmit register up by one, with 0 entering at bit 0, so `term_tx_bit` presents bits 7 down to 0 in order. `tx_ready` returns to 1 on the edge that takes the eighth strobe, and `term_tx_bit` is then 0.
- R8: While `tx_ready` is 1, transmit strobes are ignored. `term_tx_bit` stays 0 and `tx_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| term_rx_strobe | input | 1 | Terminal marks a valid receive bit |
| term_rx_bit | input | 1 | Serial data from the terminal |
| term_tx_strobe | input | 1 | Terminal takes the current transmit bit |
| term_tx_bit | output | 1 | Serial data to the terminal (MSB of transmit register) |
| cpu_rd | input | 1 | Processor takes the received character |
| cpu_ld | input | 1 | Processor loads a character for transmission |
| cpu_wdata | input | 8 | Character from the accumulator |
| cpu_rdata | output | 8 | Receive register, seen in parallel |
| rx_full | output | 1 | A complete character is held |
| tx_ready | output | 1 | Device ready for a new character |

## Verification
The bench builds the block with its default 8-bit character width, so the 3-bit bit counters run their full range and wrap on every character. This makes the eighth-bit boundary, the frozen receive counter during a lock and the ready return on the last transmit strobe all reachable. Six vector pairs drive both directions with alternating, all-ones, all-zeros and single-bit patterns. Directed cases then cover partial characters, locked input, a load while busy and strobes while idle.

// File: rtl/term_pkg.sv
package term_pkg;
    localparam int  TERM_CHAR_W  = 8;
    localparam logic RX_FULL_RST = 1'b0;
    localparam logic TX_RDY_RST  = 1'b1;
endpackage

// File: rtl/term_rx_shift.sv
module term_rx_shift #(
    parameter int CHAR_W = term_pkg::TERM_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic              bit_i,
    input  logic              read_i,
    output logic [CHAR_W-1:0] char_o,
    output logic              full_o
);
    localparam int CNT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHAR_W - 1);

    typedef struct packed {
        logic [CHAR_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              full;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.full) begin
            if (read_i) begin
                st_d.full = 1'b0;
            end
        end else if (strobe_i) begin
            st_d.shreg = {st_q.shreg[CHAR_W-2:0], bit_i};
            if (st_q.cnt == LAST_IDX) begin
                st_d.cnt  = '0;
                st_d.full = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shreg <= '0;
            st_q.cnt   <= '0;
            st_q.full  <= term_pkg::RX_FULL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign char_o = st_q.shreg;
    assign full_o = st_q.full;

    AST_RX_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |=> $stable(st_q.shreg)); // R3
    AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full && read_i |=> !st_q.full); // R4
    AST_RX_FULL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.full && !strobe_i |=> !st_q.full && $stable(st_q.shreg)); // R2
endmodule

// File: rtl/term_tx_shift.sv
module term_tx_shift #(
    parameter int CHAR_W = term_pkg::TERM_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CHAR_W-1:0] data_i,
    input  logic              strobe_i,
    output logic              bit_o,
    output logic              ready_o
);
    localparam int CNT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHAR_W - 1);

    typedef struct packed {
        logic [CHAR_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              ready;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ready) begin
            if (load_i) begin
                st_d.shreg = data_i;
                st_d.cnt   = '0;
                st_d.ready = 1'b0;
            end
        end else if (strobe_i) begin
            st_d.shreg = {st_q.shreg[CHAR_W-2:0], 1'b0};
            if (st_q.cnt == LAST_IDX) begin
                st_d.cnt   = '0;
                st_d.ready = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shreg <= '0;
            st_q.cnt   <= '0;
            st_q.ready <= term_pkg::TX_RDY_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o   = st_q.shreg[CHAR_W-1];
    assign ready_o = st_q.ready;

    AST_TX_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ready && load_i |=> !st_q.ready && (st_q.shreg == $past(data_i))); // R5
    AST_TX_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ready && !strobe_i |=> !st_q.ready && $stable(st_q.shreg)); // R6
    AST_TX_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ready && !load_i |=> st_q.ready && $stable(st_q.shreg)); // R8
endmodule

// File: rtl/serial_term_port.sv
module serial_term_port #(
    parameter int CHAR_W = term_pkg::TERM_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              term_rx_strobe,
    input  logic              term_rx_bit,
    input  logic              term_tx_strobe,
    output logic              term_tx_bit,
    input  logic              cpu_rd,
    input  logic              cpu_ld,
    input  logic [CHAR_W-1:0] cpu_wdata,
    output logic [CHAR_W-1:0] cpu_rdata,
    output logic              rx_full,
    output logic              tx_ready
);
    term_rx_shift #(.CHAR_W(CHAR_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (term_rx_strobe),
        .bit_i    (term_rx_bit),
        .read_i   (cpu_rd),
        .char_o   (cpu_rdata),
        .full_o   (rx_full)
    );

    term_tx_shift #(.CHAR_W(CHAR_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cpu_ld),
        .data_i   (cpu_wdata),
        .strobe_i (term_tx_strobe),
        .bit_o    (term_tx_bit),
        .ready_o  (tx_ready)
    );

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !term_tx_bit); // R7
endmodule

// File: tb/test_serial_term_port.sv
module test_serial_term_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       term_rx_strobe = 1'b0, term_rx_bit = 1'b0, term_tx_strobe = 1'b0;
    logic       term_tx_bit;
    logic       cpu_rd = 1'b0, cpu_ld = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       rx_full, tx_ready;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    serial_term_port i_serial_term_port (
        .clk(clk), .rst_n(rst_n),
        .term_rx_strobe(term_rx_strobe), .term_rx_bit(term_rx_bit),
        .term_tx_strobe(term_tx_strobe), .term_tx_bit(term_tx_bit),
        .cpu_rd(cpu_rd), .cpu_ld(cpu_ld), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .rx_full(rx_full), .tx_ready(tx_ready)
    );

    localparam int NVEC = 6;
    // {char sent by terminal, char loaded by processor}
    localparam logic [15:0] VEC [NVEC] = '{
        16'hA5_3C, 16'hFF_00, 16'h00_FF, 16'h80_01, 16'h01_80, 16'h5A_C3
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rx_bits(input logic [7:0] ch, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk);
            term_rx_strobe = 1'b1;
            term_rx_bit = ch[i];
            @(negedge clk);
            term_rx_strobe = 1'b0;
        end
    endtask

    task automatic cpu_read();
        @(negedge clk); cpu_rd = 1'b1;
        @(negedge clk); cpu_rd = 1'b0;
    endtask

    task automatic cpu_load(input logic [7:0] v);
        @(negedge clk); cpu_wdata = v; cpu_ld = 1'b1;
        @(negedge clk); cpu_ld = 1'b0;
    endtask

    task automatic tx_take(output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            got[i] = term_tx_bit;
            term_tx_strobe = 1'b1;
            @(negedge clk);
            term_tx_strobe = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rx_full == 1'b0, "R1 rx_full", rx_full, 0);
        check(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
        check(term_tx_bit == 1'b0, "R1 tx_bit", term_tx_bit, 0);
        check(cpu_rdata == 8'h00, "R1 rdata", cpu_rdata, 0);

        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] rch, tch;
            rch = VEC[v][15:8];
            tch = VEC[v][7:0];
            rx_bits(rch, 8);
            check(rx_full == 1'b1, "R2 full after 8 bits", rx_full, 1);
            check(cpu_rdata == rch, "R2 char MSB first", cpu_rdata, rch);
            cpu_read();
            check(rx_full == 1'b0, "R4 read clears", rx_full, 0);
            check(cpu_rdata == rch, "R4 parallel data", cpu_rdata, rch);
            cpu_load(tch);
            check(tx_ready == 1'b0, "R5 load clears ready", tx_ready, 0);
            check(term_tx_bit == tch[7], "R5 first bit", term_tx_bit, tch[7]);
            tx_take(got);
            check(got == tch, "R7 serial out", got, tch);
            check(tx_ready == 1'b1, "R7 ready after 8", tx_ready, 1);
            check(term_tx_bit == 1'b0, "R7 line low", term_tx_bit, 0);
        end

        // R2 seven bits do not complete a character
        rx_bits(8'hC6, 7);
        check(rx_full == 1'b0, "R2 partial", rx_full, 0);
        rx_bits(8'h0C, 1);
        check(rx_full == 1'b1, "R2 eighth bit", rx_full, 1);
        check(cpu_rdata == 8'hC6, "R2 partial then last", cpu_rdata, 8'hC6);

        // R3 locked while full
        rx_bits(8'h39, 8);
        check(cpu_rdata == 8'hC6, "R3 locked data", cpu_rdata, 8'hC6);
        check(rx_full == 1'b1, "R3 still full", rx_full, 1);
        rx_bits(8'hFF, 3);
        cpu_read();
        check(cpu_rdata == 8'hC6, "R3 data after read", cpu_rdata, 8'hC6);
        rx_bits(8'h72, 7);
        check(rx_full == 1'b0, "R3 counter frozen", rx_full, 0);
        rx_bits(8'h72 << 7, 1);
        check(cpu_rdata == 8'h72, "R3 fresh char", cpu_rdata, 8'h72);
        cpu_read();

        // R6 load while busy ignored
        cpu_load(8'h81);
        cpu_load(8'h7E);
        check(tx_ready == 1'b0, "R6 still busy", tx_ready, 0);
        tx_take(got);
        check(got == 8'h81, "R6 char unchanged", got, 8'h81);
        check(tx_ready == 1'b1, "R6 ready after", tx_ready, 1);

        // R8 strobes while idle ignored
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); term_tx_strobe = 1'b1;
            @(negedge clk); term_tx_strobe = 1'b0;
            check(term_tx_bit == 1'b0, "R8 idle line", term_tx_bit, 0);
            check(tx_ready == 1'b1, "R8 idle ready", tx_ready, 1);
        end
        cpu_load(8'hB4);
        tx_take(got);
        check(got == 8'hB4, "R8 next char intact", got, 8'hB4);

        finish_run();
    end
endmodule